// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block is the shared front end of a small multiprocessor interrupt controller. For each interrupt ID it holds an enable bit, pending state, a trigger mode and a CPU routing mask. It accepts raw interrupt lines and a word-wide register bus. Each cycle it offers every CPU interface one request and the ID of that request. Where several interrupts are eligible, the lowest ID wins.

IDs 0 to 15 are software interrupts, and a trigger register sets them pending for individual CPUs. IDs 16 to 31 are private lines that are always level-sensitive and reach every CPU. IDs 32 and up are shared lines, each with its own trigger mode and CPU mask. A single control bit gates all forwarding. Software disables a CPU's interrupts at the distributor by clearing enables and routing masks before the CPU interface is shut down.

Register map (word addresses): control at 0x00, type at 0x01, software trigger at 0x02, set-enable words at 0x08+w, clear-enable words at 0x10+w, clear-pending words at 0x18+w, trigger configuration at 0x20+w, routing at 0x40+w.

Top module: `irq_distributor`

## Requirements
- R1: After reset, control, all enables, all pending state, the shared trigger bits and all routing bytes are zero, and every irq_req is low.
- R2: The type word at 0x01 reads {24'b0, NUM_CPU-1 in bits [7:5], NUM_IRQ/32-1 in bits [4:0]}. The default build reads 0x21.
- R3: Writing 1 to bit b of word 0x08+w enables ID 32w+b, and writing 1 to the same bit at 0x10+w disables it. Zero bits change nothing. Both words read back the enable state.
- R4: Bit 0 of the control word at 0x00 gates forwarding. While it is 0, no irq_req is asserted, and its value changes only through a write to 0x00.
- R5: With trigger bit 0, a shared ID is pending exactly while its input is high. A clear-pending write does not remove this state. Private IDs 16 to 31 always behave this way.
- R6: With trigger bit 1 (bit 2k+1 of word 0x20+ID/16, k = ID mod 16), a shared ID latches pending on a rising input edge. It stays pending after the input falls, until a 1 is written to its bit in clear-pending word 0x18+ID/32. Those words read back the pending state.
- R7: Only the odd bit of each trigger pair is stored, and only for IDs 32 and up. Words covering IDs 0-15 read 0xAAAAAAAA, words covering IDs 16-31 read 0, and writes to both are ignored.
- R8: Routing word 0x40+ID/4 holds byte ID mod 4 for each ID. Bit c of that byte sends the ID to CPU c, and bits at or above NUM_CPU read 0. Bytes for IDs below 32 read 0 and ignore writes. Private IDs reach every CPU.
- R9: Each CPU receives the lowest-numbered ID that is enabled, pending and routed to it.
- R10: A write to 0x02 sets software ID wdata[3:0] pending for a set of CPUs chosen by the filter in bits [25:24]. Filter 0 selects the mask in bits [23:16], filter 1 selects every CPU except bus_cpu, filter 2 selects bus_cpu only, and filter 3 selects no CPU. Word 0x18 bits [15:0] read and clear bus_cpu's own software pending bits.
- R11: Addresses outside the implemented words read zero, and writes to them change nothing.
- R12: bus_rdata carries the addressed word on the edge after a cycle with bus_re. A level input high at an edge shows on irq_req/irq_id at that edge. An edge input shows one edge later. Register writes show on the outputs one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | 3 | Number of the CPU making the access |
| bus_rdata | output | 32 | Read data, registered |
| irq_in | input | NUM_IRQ | Raw interrupt lines, bit = ID (bits 15:0 unused) |
| irq_req | output | NUM_CPU | Request per CPU interface |
| irq_id | output | NUM_CPU*IDW | Forwarded ID per CPU, CPU c in bits [c*IDW +: IDW] |

## Verification
The bench drives a level line on and off with forwarding gated and then ungated, which separates the control gate from the level path. It pulses an edge line and checks the request after the line has fallen, which tells a latched edge from a followed level. Two lines routed to different CPUs are raised together and then one at a time, which exposes both the lowest-ID order and the per-CPU masks. Software triggers are issued with each filter from two different requesters, so a wrong self or others decode, or a reserved filter that is not ignored, shows up on the other CPU's request.

// File: rtl/irqd_pkg.sv
// Shared constants for the interrupt distributor: register word addresses
// and the software-trigger filter encoding. Assumes 8-bit word addressing.
package irqd_pkg;
    localparam int          ADDR_W     = 8;
    localparam int          SGI_N      = 16;
    localparam int          SPI_FIRST  = 32;
    localparam logic [7:0]  A_CTRL     = 8'h00;
    localparam logic [7:0]  A_TYPE     = 8'h01;
    localparam logic [7:0]  A_SWTRIG   = 8'h02;
    localparam logic [7:0]  A_SETEN    = 8'h08;   // 8-word window
    localparam logic [7:0]  A_CLREN    = 8'h10;   // 8-word window
    localparam logic [7:0]  A_CLRPEND  = 8'h18;   // 8-word window
    localparam logic [7:0]  A_TRIG     = 8'h20;   // 16-word window
    localparam logic [7:0]  A_ROUTE    = 8'h40;   // 64-word window

    typedef enum logic [1:0] {
        SWF_LIST   = 2'd0,
        SWF_OTHERS = 2'd1,
        SWF_SELF   = 2'd2,
        SWF_NONE   = 2'd3
    } sw_filter_e;
endpackage

// File: rtl/irqd_state.sv
// Register file and pending logic of the distributor. Holds enables, shared
// trigger modes, routing bytes, edge latches and per-CPU software pending
// bits, and serves the register bus. Assumes NUM_IRQ is a multiple of 32,
// at least 64, and NUM_CPU is 1..8.
module irqd_state
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_we,
    input  logic                         bus_re,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    input  logic [2:0]                   bus_cpu,
    output logic [31:0]                  bus_rdata,
    input  logic [NUM_IRQ-1:0]           irq_in,
    output logic                         glob_en,
    output logic [NUM_IRQ-1:0]           enable,
    output logic [NUM_IRQ-1:0]           pending,
    output logic [NUM_CPU*SGI_N-1:0]     sgi_pend,
    output logic [NUM_IRQ*NUM_CPU-1:0]   route
);
    localparam int NWORDS = NUM_IRQ / 32;

    logic                   ctrl_q;
    logic [NUM_IRQ-1:0]     en_q;
    logic [NUM_IRQ-1:SPI_FIRST] edge_q, latch_q, prev_q;
    logic [NUM_CPU-1:0]     tgt_q   [SPI_FIRST:NUM_IRQ-1];
    logic [NUM_CPU-1:0]     tgt_full[NUM_IRQ];
    logic [NUM_IRQ-1:0]     trig_full;
    logic [SGI_N-1:0]       sgi_q   [NUM_CPU];
    logic [SGI_N-1:0]       sgi_set [NUM_CPU];
    logic [SGI_N-1:0]       sgi_clr [NUM_CPU];
    logic [SGI_N-1:0]       sgi_view;
    logic [NUM_CPU-1:0]     self_cpu, sw_dst;
    logic [31:0]            rd_d;
    logic                   hit_set, hit_clr, hit_cp, hit_trig, hit_route, hit_sw;
    logic                   unused_bits;

    assign unused_bits = ^{bus_wdata[31:26], bus_wdata[15:4], irq_in[SGI_N-1:0]};

    // Decode the register window the address falls in.
    assign hit_set   = (bus_addr & 8'hF8) == A_SETEN;
    assign hit_clr   = (bus_addr & 8'hF8) == A_CLREN;
    assign hit_cp    = (bus_addr & 8'hF8) == A_CLRPEND;
    assign hit_trig  = (bus_addr & 8'hF0) == A_TRIG;
    assign hit_route = (bus_addr & 8'hC0) == A_ROUTE;
    assign hit_sw    = bus_we && (bus_addr == A_SWTRIG);

    // Per-ID pending view, trigger view and routing by ID class.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_id
        if (g < SGI_N) begin : g_sw
            assign pending[g]   = 1'b0;
            assign trig_full[g] = 1'b1;
            assign tgt_full[g]  = '0;
            assign route[g*NUM_CPU +: NUM_CPU] = '1;
        end else if (g < SPI_FIRST) begin : g_priv
            assign pending[g]   = irq_in[g];
            assign trig_full[g] = 1'b0;
            assign tgt_full[g]  = '0;
            assign route[g*NUM_CPU +: NUM_CPU] = '1;
        end else begin : g_shared
            assign pending[g]   = edge_q[g] ? latch_q[g] : irq_in[g];
            assign trig_full[g] = edge_q[g];
            assign tgt_full[g]  = tgt_q[g];
            assign route[g*NUM_CPU +: NUM_CPU] = tgt_q[g];
        end
    end

    // Pick the CPUs a software-trigger write targets.
    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) self_cpu[c] = (int'(bus_cpu) == c);
        case (sw_filter_e'(bus_wdata[25:24]))
            SWF_LIST:   sw_dst = bus_wdata[16 +: NUM_CPU];
            SWF_OTHERS: sw_dst = ~self_cpu;
            SWF_SELF:   sw_dst = self_cpu;
            default:    sw_dst = '0;
        endcase
    end

    // Form software pending set/clear masks and the requester's view.
    always_comb begin
        sgi_view = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            sgi_set[c] = (hit_sw && sw_dst[c]) ? (SGI_N'(1) << bus_wdata[3:0]) : '0;
            sgi_clr[c] = (bus_we && hit_cp && bus_addr[2:0] == 3'd0 && self_cpu[c])
                         ? bus_wdata[SGI_N-1:0] : '0;
            if (self_cpu[c]) sgi_view = sgi_q[c];
        end
    end

    // Control bit and software pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 1'b0;
            for (int c = 0; c < NUM_CPU; c++) sgi_q[c] <= '0;
        end else begin
            if (bus_we && bus_addr == A_CTRL) ctrl_q <= bus_wdata[0];
            for (int c = 0; c < NUM_CPU; c++) sgi_q[c] <= (sgi_q[c] & ~sgi_clr[c]) | sgi_set[c];
        end
    end

    // Write-one-to-set and write-one-to-clear enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (bus_we && hit_set && int'(bus_addr[2:0]) == i / 32 && bus_wdata[i % 32])
                    en_q[i] <= 1'b1;
                else if (bus_we && hit_clr && int'(bus_addr[2:0]) == i / 32 && bus_wdata[i % 32])
                    en_q[i] <= 1'b0;
            end
        end
    end

    // Shared IDs: trigger bit, routing byte, edge latch (set wins over clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q  <= '0;
            latch_q <= '0;
            prev_q  <= '0;
            for (int i = SPI_FIRST; i < NUM_IRQ; i++) tgt_q[i] <= '0;
        end else begin
            prev_q <= irq_in[NUM_IRQ-1:SPI_FIRST];
            for (int i = SPI_FIRST; i < NUM_IRQ; i++) begin
                if (bus_we && hit_trig && int'(bus_addr[3:0]) == i / 16)
                    edge_q[i] <= bus_wdata[2*(i % 16) + 1];
                if (bus_we && hit_route && int'(bus_addr[5:0]) == i / 4)
                    tgt_q[i] <= bus_wdata[8*(i % 4) +: NUM_CPU];
                if (edge_q[i] && irq_in[i] && !prev_q[i])
                    latch_q[i] <= 1'b1;
                else if (bus_we && hit_cp && int'(bus_addr[2:0]) == i / 32 && bus_wdata[i % 32])
                    latch_q[i] <= 1'b0;
            end
        end
    end

    // Read mux: unimplemented words fall through as zero.
    always_comb begin
        rd_d = '0;
        if (bus_addr == A_CTRL) begin
            rd_d[0] = ctrl_q;
        end else if (bus_addr == A_TYPE) begin
            rd_d[7:0] = {3'(NUM_CPU - 1), 5'(NWORDS - 1)};
        end else if (hit_set || hit_clr) begin
            for (int k = 0; k < NWORDS; k++)
                if (int'(bus_addr[2:0]) == k) rd_d = en_q[k*32 +: 32];
        end else if (hit_cp) begin
            for (int k = 0; k < NWORDS; k++)
                if (int'(bus_addr[2:0]) == k) rd_d = pending[k*32 +: 32];
            if (bus_addr[2:0] == 3'd0) rd_d[SGI_N-1:0] = sgi_view;
        end else if (hit_trig) begin
            for (int i = 0; i < NUM_IRQ; i++)
                if (int'(bus_addr[3:0]) == i / 16) rd_d[2*(i % 16) + 1] = trig_full[i];
        end else if (hit_route) begin
            for (int i = 0; i < NUM_IRQ; i++)
                if (int'(bus_addr[5:0]) == i / 4) rd_d[8*(i % 4) +: NUM_CPU] = tgt_full[i];
        end
    end

    // Register read data one edge after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_d;
    end

    assign glob_en = ctrl_q;
    assign enable  = en_q;
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_sgi_out
        assign sgi_pend[c*SGI_N +: SGI_N] = sgi_q[c];
    end

    // R3
    set_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SETEN && bus_wdata[0]) |=> en_q[0]);
    // R3
    clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CLREN && bus_wdata[0]) |=> !en_q[0]);
    // R4
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_CTRL) |=> $stable(ctrl_q));
    // R6
    edge_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_q[SPI_FIRST] && irq_in[SPI_FIRST] && !prev_q[SPI_FIRST]) |=> latch_q[SPI_FIRST]);
endmodule

// File: rtl/irqd_pick.sv
// Fixed-order selector for one CPU interface: registers the lowest-numbered
// candidate ID as a request, gated by the global forwarding enable.
// Assumes candidates already include enable, pending and routing.
module irqd_pick #(
    parameter int NUM_IRQ = 64,
    parameter int IDW     = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glob_en,
    input  logic [NUM_IRQ-1:0] cand,
    output logic               req_q,
    output logic [IDW-1:0]     id_q
);
    logic           hit;
    logic [IDW-1:0] sel;
    logic [NUM_IRQ-1:0] below_id;

    // Scan from the top so the lowest set bit is kept last.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit = 1'b1;
                sel = IDW'(i);
            end
        end
    end

    // Register the forwarded request and ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            id_q  <= '0;
        end else begin
            req_q <= glob_en && hit;
            id_q  <= (glob_en && hit) ? sel : '0;
        end
    end

    assign below_id = ~({NUM_IRQ{1'b1}} << id_q);

    // R4
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> !req_q);
    // R9
    chosen_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> ((($past(cand) >> id_q) & NUM_IRQ'(1)) != '0));
    // R9
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> (($past(cand) & below_id) == '0));
endmodule

// File: rtl/irq_distributor.sv
// Top of the interrupt distributor: register/pending state plus one
// fixed-order selector per CPU interface. Assumes NUM_IRQ is a multiple of
// 32 and at least 64, and NUM_CPU is 1..8.
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    parameter int IDW     = $clog2(NUM_IRQ)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we,
    input  logic                   bus_re,
    input  logic [7:0]             bus_addr,
    input  logic [31:0]            bus_wdata,
    input  logic [2:0]             bus_cpu,
    output logic [31:0]            bus_rdata,
    input  logic [NUM_IRQ-1:0]     irq_in,
    output logic [NUM_CPU-1:0]     irq_req,
    output logic [NUM_CPU*IDW-1:0] irq_id
);
    logic                         glob_en;
    logic [NUM_IRQ-1:0]           enable, pending;
    logic [NUM_CPU*SGI_N-1:0]     sgi_pend;
    logic [NUM_IRQ*NUM_CPU-1:0]   route;

    irqd_state #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) i_state (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
        .bus_rdata(bus_rdata), .irq_in(irq_in), .glob_en(glob_en),
        .enable(enable), .pending(pending), .sgi_pend(sgi_pend), .route(route)
    );

    // One candidate vector and selector per CPU interface.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_IRQ-1:0] routed, cand;
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
            assign routed[i] = route[i*NUM_CPU + c];
        end
        assign cand = enable & ((pending & routed)
                    | {{(NUM_IRQ-SGI_N){1'b0}}, sgi_pend[c*SGI_N +: SGI_N]});

        irqd_pick #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) i_pick (
            .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .cand(cand),
            .req_q(irq_req[c]), .id_q(irq_id[c*IDW +: IDW])
        );
    end
endmodule

// File: tb/test_irq_distributor.sv
module test_irq_distributor;
    localparam int NI = 64, NC = 2, IW = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [2:0] bus_cpu = '0;
    logic [31:0] bus_rdata;
    logic [NI-1:0] irq_in = '0;
    logic [NC-1:0] irq_req;
    logic [NC*IW-1:0] irq_id;

    int checks = 0, fails = 0;
    logic issued = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    irq_distributor i_irq_distributor (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
        .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_req(irq_req), .irq_id(irq_id)
    );

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // Driver: issue a read and queue its expected value.
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic chk_irq(input int c, input logic r, input logic [IW-1:0] id, input string tag);
        checks++;
        if (irq_req[c] !== r || irq_id[c*IW +: IW] !== id) begin
            fails++;
            $display("FAIL %s cpu%0d: req=%0b id=%0d expected req=%0b id=%0d",
                     tag, c, irq_req[c], irq_id[c*IW +: IW], r, id);
        end
    endtask

    // Monitor: compare read data the edge after each read strobe.
    always @(posedge clk) issued <= bus_re;
    always @(negedge clk) begin
        if (issued && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: rdata=%08h expected %08h", t, bus_rdata, e);
            end
        end
    end

    initial begin
        #(200000 * 10);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk_irq(0, 1'b0, 0, "R1"); chk_irq(1, 1'b0, 0, "R1");
        rd(8'h00, 32'h0, "R1 ctrl");
        rd(8'h08, 32'h0, "R1 enable");
        rd(8'h48, 32'h0, "R1 route");
        rd(8'h22, 32'h0, "R1 trigger");
        rd(8'h01, 32'h21, "R2 type");

        // R3 set/clear enable pairs
        wr(8'h08, 32'h5);  rd(8'h08, 32'h5, "R3 set");
        rd(8'h10, 32'h5, "R3 clr view");
        wr(8'h10, 32'h1);  rd(8'h08, 32'h4, "R3 clear");
        wr(8'h08, 32'h0);  rd(8'h08, 32'h4, "R3 zero bits");
        wr(8'h10, 32'h4);  rd(8'h08, 32'h0, "R3 clear2");

        // R11 unimplemented words
        wr(8'h0A, 32'hFFFF_FFFF); rd(8'h0A, 32'h0, "R11 enable word");
        rd(8'h08, 32'h0, "R11 no alias");
        rd(8'h24, 32'h0, "R11 trigger word");
        rd(8'h50, 32'h0, "R11 route word");
        rd(8'h03, 32'h0, "R11 gap");

        // R7 trigger configuration
        rd(8'h20, 32'hAAAA_AAAA, "R7 sw trig");
        wr(8'h21, 32'hFFFF_FFFF); rd(8'h21, 32'h0, "R7 private trig");
        wr(8'h22, 32'h3); rd(8'h22, 32'h2, "R7 shared odd bit");

        // R8 routing bytes: id32->cpu0, id33->both, id34->cpu0, id35->cpu1
        wr(8'h48, 32'h0201_FF01); rd(8'h48, 32'h0201_0301, "R8 route mask");
        wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, 32'h0, "R8 low ids");

        // R4 gate, R5 level
        wr(8'h09, 32'hF);
        irq_in[34] = 1'b1; idle(1);
        chk_irq(0, 1'b0, 0, "R4 gated"); chk_irq(1, 1'b0, 0, "R4 gated");
        wr(8'h00, 32'h1); idle(1);
        chk_irq(0, 1'b1, 34, "R5 level"); chk_irq(1, 1'b0, 0, "R8 not routed");
        irq_in[34] = 1'b0; idle(1);
        chk_irq(0, 1'b0, 0, "R12 level drop");

        // R9 lowest ID wins
        irq_in[35] = 1'b1; irq_in[33] = 1'b1; idle(1);
        chk_irq(0, 1'b1, 33, "R9 cpu0"); chk_irq(1, 1'b1, 33, "R9 cpu1");
        irq_in[33] = 1'b0; idle(1);
        chk_irq(0, 1'b0, 0, "R9 cpu0 none"); chk_irq(1, 1'b1, 35, "R9 cpu1 next");
        irq_in[35] = 1'b0;

        // R6 edge latch
        irq_in[32] = 1'b1; idle(1);
        irq_in[32] = 1'b0; idle(1);
        chk_irq(0, 1'b1, 32, "R6 latched"); chk_irq(1, 1'b0, 0, "R6 cpu1");
        rd(8'h19, 32'h1, "R6 pending view");
        wr(8'h19, 32'h1); idle(1);
        chk_irq(0, 1'b0, 0, "R6 cleared");
        rd(8'h19, 32'h0, "R6 pending gone");
        irq_in[34] = 1'b1;
        wr(8'h19, 32'h4);
        rd(8'h19, 32'h4, "R5 clear no effect");
        chk_irq(0, 1'b1, 34, "R5 still pending");
        irq_in[34] = 1'b0;

        // R8 private IDs reach every CPU
        wr(8'h08, 32'h0010_0000);
        irq_in[20] = 1'b1; idle(1);
        chk_irq(0, 1'b1, 20, "R8 private"); chk_irq(1, 1'b1, 20, "R8 private");
        irq_in[20] = 1'b0;

        // R10 software trigger filters
        wr(8'h08, 32'h2A);
        bus_cpu = 3'd0; wr(8'h02, 32'h0002_0003); idle(1);
        chk_irq(0, 1'b0, 0, "R10 list"); chk_irq(1, 1'b1, 3, "R10 list");
        bus_cpu = 3'd1; wr(8'h02, 32'h0100_0005); idle(1);
        chk_irq(0, 1'b1, 5, "R10 others"); chk_irq(1, 1'b1, 3, "R10 others");
        bus_cpu = 3'd0; wr(8'h02, 32'h0200_0003); idle(1);
        chk_irq(0, 1'b1, 3, "R10 self");
        wr(8'h02, 32'h0300_FF01); idle(1);
        chk_irq(0, 1'b1, 3, "R10 reserved"); chk_irq(1, 1'b1, 3, "R10 reserved");
        wr(8'h18, 32'h8); idle(1);
        chk_irq(0, 1'b1, 5, "R10 own clear"); chk_irq(1, 1'b1, 3, "R10 other kept");
        bus_cpu = 3'd1; rd(8'h18, 32'h8, "R10 cpu1 view");
        bus_cpu = 3'd0; rd(8'h18, 32'h20, "R10 cpu0 view");

        // R4 global disable
        wr(8'h00, 32'h0); idle(1);
        chk_irq(0, 1'b0, 0, "R4 off"); chk_irq(1, 1'b0, 0, "R4 off");

        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R12: %0d reads unanswered, expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule